// File: doc/BRIEF.md
# Buffered Asynchronous Serial Receiver

This block receives one asynchronous serial line and turns it into a stream of characters. The line is sampled on a 16x oversampling enable (`rx_tick`), which a baud-rate generator outside the block supplies. A character has 5 to 8 data bits, sent least significant bit first, and an optional parity bit. A high level on the line is mark and a low level is space.

Each finished character is written, together with its error flags, into a four-entry holding buffer. A consumer drains the buffer through a valid/ready output. The head entry is presented while `out_valid` is high and is removed on every clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the head entry and its flags stay unchanged. The receiver itself cannot be stalled: a character that arrives while the buffer is full and no pop is taking place is dropped, and the loss is flagged on the newest stored entry. When flow control is enabled, the full flag drives an active-low request-to-send output, so the far-end transmitter can be held off.

The block also rejects false start bits, reports framing and parity errors, and detects line breaks, including a break that begins partway through a character.

Top module: `serial_rx_buf`

## Requirements
- R1: `len_sel` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits are received least significant first, and the unused upper bits of `out_data` read as zero.
- R2: `par_mode` selects the parity mode: 0 none, 1 even, 2 odd, 3 fixed to the value of `par_force`. When the received parity bit differs from the expected one, status bit 0 (parity error) is set.
- R3: When the line is low at the stop bit sample, status bit 1 (framing error) is set.
- R4: A falling edge whose line is high again at the 8th tick after detection is a false start. It produces no character, and the receiver returns to idle.
- R5: The buffer holds four entries. `out_valid` is high while at least one entry is held, and `buf_full` is high while all four are held. An entry is removed on an edge where `out_valid` and `out_ready` are both high; otherwise the head data and status stay stable.
- R6: A character that completes while the buffer is full and no pop happens is discarded. Status bit 3 (overrun) of the newest stored entry is set.
- R7: When every sampled bit of a frame is low, including parity and stop, one break entry is stored: data 0 and status 4'b0110 (break and framing). At the same time `brk_start` pulses for one cycle. No further entry is stored until the line is seen at mark, and at that point `brk_end` pulses for one cycle.
- R8: After a framing error, the low stop sample itself serves as the start bit of the next character. A break that begins mid-character therefore yields the partial character with a framing error, followed by a break entry.
- R9: When `flow_en` is 1, `rts_n` equals `buf_full`. When `flow_en` is 0, `rts_n` is 0.
- R10: The start bit is validated at the 8th tick after the falling edge is seen, and each later bit is sampled 16 ticks after the previous sample.
- R11: After reset, `out_valid`, `buf_full`, `rts_n`, `brk_start` and `brk_end` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_tick | input | 1 | 16x oversampling enable, one cycle wide |
| rx_line | input | 1 | Serial line, asynchronous to `clk` |
| len_sel | input | 2 | Data length code (R1) |
| par_mode | input | 2 | Parity mode code (R2) |
| par_force | input | 1 | Parity value used in fixed mode |
| flow_en | input | 1 | Enables automatic request-to-send control |
| out_valid | output | 1 | Buffer not empty; the head entry is presented |
| out_ready | input | 1 | Consumer accepts the head entry |
| out_data | output | 8 | Head entry data |
| out_stat | output | 4 | Head entry status: bit 3 overrun, bit 2 break, bit 1 framing, bit 0 parity |
| buf_full | output | 1 | All four entries occupied |
| rts_n | output | 1 | Active-low request to send |
| brk_start | output | 1 | One-cycle pulse when a break is recorded |
| brk_end | output | 1 | One-cycle pulse when the line returns to mark after a break |

## Verification
The notable same-cycle overlap is a stop-bit sample that is low: in one tick it closes the current character with a framing error and opens the next character's start bit. The bench provokes this in two ways. First, it sends a frame with a low stop bit followed by idle mark, and expects the flagged character and then an 0xFF character. Second, it sends a line that drops to space midway through a character and stays there, and expects the partial character and then one break entry. A second overlap, a push arriving in the same cycle as a pop while the buffer is full, is guarded by the buffer's occupancy assertions. At the ports this path is judged by the order and the flags of the entries drained after an overrun.

// File: rtl/rxb_pkg.sv
`timescale 1ns/1ps
package rxb_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRKW
  } rx_state_e;

  localparam logic [1:0] PAR_NONE  = 2'd0;
  localparam logic [1:0] PAR_EVEN  = 2'd1;
  localparam logic [1:0] PAR_ODD   = 2'd2;
  localparam logic [1:0] PAR_FIXED = 2'd3;

  typedef struct packed {
    logic              brk;
    logic              fe;
    logic              pe;
    logic [CHAR_W-1:0] data;
  } rx_char_t;
endpackage

// File: rtl/rxb_sync.sv
`timescale 1ns/1ps
module rxb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rxb_framer.sv
`timescale 1ns/1ps
module rxb_framer
  import rxb_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        rx,
  input  logic [1:0]  len_sel,
  input  logic [1:0]  par_mode,
  input  logic        par_force,
  output logic        push,
  output rx_char_t    push_char,
  output logic        brk_start,
  output logic        brk_end
);
  localparam int TW = $clog2(OSR);
  localparam int BW = $clog2(CHAR_W);
  localparam logic [TW-1:0] T_MID = TW'(OSR/2 - 1);
  localparam logic [TW-1:0] T_END = TW'(OSR - 1);

  rx_state_e         state;
  logic [TW-1:0]     tcnt;
  logic [BW-1:0]     bcnt;
  logic [CHAR_W-1:0] shreg;
  logic              par_acc, par_bit, any_one;
  logic [BW-1:0]     last_idx;
  logic              exp_par, pe_now;

  assign last_idx = BW'(4) + BW'(len_sel);

  always_comb begin
    unique case (par_mode)
      PAR_EVEN: exp_par = par_acc;
      PAR_ODD:  exp_par = ~par_acc;
      default:  exp_par = par_force;
    endcase
    pe_now = (par_mode != PAR_NONE) && (par_bit != exp_par);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tcnt      <= '0;
      bcnt      <= '0;
      shreg     <= '0;
      par_acc   <= 1'b0;
      par_bit   <= 1'b0;
      any_one   <= 1'b0;
      push      <= 1'b0;
      push_char <= '0;
      brk_start <= 1'b0;
      brk_end   <= 1'b0;
    end else begin
      push      <= 1'b0;
      brk_start <= 1'b0;
      brk_end   <= 1'b0;
      if (tick) begin
        unique case (state)
          ST_IDLE: if (!rx) begin
            state <= ST_START;
            tcnt  <= '0;
          end
          ST_START: begin
            if (tcnt == T_MID) begin
              tcnt    <= '0;
              bcnt    <= '0;
              shreg   <= '0;
              par_acc <= 1'b0;
              any_one <= 1'b0;
              state   <= rx ? ST_IDLE : ST_DATA;
            end else tcnt <= tcnt + 1'b1;
          end
          ST_DATA: begin
            if (tcnt == T_END) begin
              tcnt        <= '0;
              shreg[bcnt] <= rx;
              par_acc     <= par_acc ^ rx;
              any_one     <= any_one | rx;
              if (bcnt == last_idx)
                state <= (par_mode != PAR_NONE) ? ST_PAR : ST_STOP;
              else
                bcnt <= bcnt + 1'b1;
            end else tcnt <= tcnt + 1'b1;
          end
          ST_PAR: begin
            if (tcnt == T_END) begin
              tcnt    <= '0;
              par_bit <= rx;
              any_one <= any_one | rx;
              state   <= ST_STOP;
            end else tcnt <= tcnt + 1'b1;
          end
          ST_STOP: begin
            if (tcnt == T_END) begin
              tcnt <= '0;
              push <= 1'b1;
              if (rx) begin
                push_char <= '{brk: 1'b0, fe: 1'b0, pe: pe_now, data: shreg};
                state     <= ST_IDLE;
              end else if (!any_one) begin
                push_char <= '{brk: 1'b1, fe: 1'b1, pe: 1'b0, data: '0};
                brk_start <= 1'b1;
                state     <= ST_BRKW;
              end else begin
                push_char <= '{brk: 1'b0, fe: 1'b1, pe: pe_now, data: shreg};
                bcnt      <= '0;
                shreg     <= '0;
                par_acc   <= 1'b0;
                any_one   <= 1'b0;
                state     <= ST_DATA;
              end
            end else tcnt <= tcnt + 1'b1;
          end
          ST_BRKW: if (rx) begin
            brk_end <= 1'b1;
            state   <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R4
  false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && tick && tcnt == T_MID && rx) |=> (state == ST_IDLE && !push));

  // R7
  brk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BRKW && $past(state) == ST_BRKW) |-> !push);

  // R7
  brk_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_start |-> (push && push_char.brk && push_char.data == '0));

  // R7
  brk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_end |-> $past(state) == ST_BRKW);
endmodule

// File: rtl/rxb_fifo.sv
`timescale 1ns/1ps
module rxb_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_ready,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         rd_ovr,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem   [DEPTH];
  logic [DEPTH-1:0] ovr_q;
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic          do_pop, do_push, ovr_set;

  assign rd_valid = (count != '0);
  assign full     = (count == (AW+1)'(DEPTH));
  assign do_pop   = rd_valid && rd_ready;
  assign do_push  = wr_en && (!full || do_pop);
  assign ovr_set  = wr_en && full && !do_pop;
  assign rd_data  = mem[rptr];
  assign rd_ovr   = ovr_q[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovr_q <= '0;
    end else begin
      if (do_push) begin
        wptr        <= wptr + 1'b1;
        ovr_q[wptr] <= 1'b0;
      end
      if (ovr_set) ovr_q[wptr - 1'b1] <= 1'b1;
      if (do_pop) rptr <= rptr + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));

  // R5
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 1 && do_pop && !wr_en) |=> !rd_valid);

  // R6
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> (full && $stable(rptr) && $stable(wptr)));

  // R5
  push_pop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && do_pop) |=> full);
endmodule

// File: rtl/serial_rx_buf.sv
`timescale 1ns/1ps
module serial_rx_buf
  import rxb_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_tick,
  input  logic       rx_line,
  input  logic [1:0] len_sel,
  input  logic [1:0] par_mode,
  input  logic       par_force,
  input  logic       flow_en,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic [3:0] out_stat,
  output logic       buf_full,
  output logic       rts_n,
  output logic       brk_start,
  output logic       brk_end
);
  localparam int ENTRY_W = $bits(rx_char_t);

  logic     rx_s, push, head_ovr;
  rx_char_t push_char, head;

  rxb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s)
  );

  rxb_framer #(.OSR(OSR)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(rx_tick), .rx(rx_s),
    .len_sel(len_sel), .par_mode(par_mode), .par_force(par_force),
    .push(push), .push_char(push_char),
    .brk_start(brk_start), .brk_end(brk_end)
  );

  rxb_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_data(push_char),
    .rd_ready(out_ready), .rd_valid(out_valid), .rd_data(head),
    .rd_ovr(head_ovr), .full(buf_full)
  );

  assign out_data = head.data;
  assign out_stat = {head_ovr, head.brk, head.fe, head.pe};
  assign rts_n    = flow_en & buf_full;

  // R5
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_stat[2:0])));

  // R9
  rts_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && $rose(buf_full)) |-> rts_n);
endmodule

// File: tb/sim_serial_rx_buf.sv
`timescale 1ns/1ps
module sim_serial_rx_buf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_tick = 1'b0;
  logic       rx_line = 1'b1;
  logic [1:0] len_sel = 2'd3;
  logic [1:0] par_mode = 2'd0;
  logic       par_force = 1'b0;
  logic       flow_en = 1'b0;
  logic       out_ready = 1'b0;
  logic       out_valid, buf_full, rts_n, brk_start, brk_end;
  logic [7:0] out_data;
  logic [3:0] out_stat;

  int n_chk = 0, n_fail = 0, n_bs = 0, n_be = 0;
  logic [1:0] tdiv = '0;
  bit done = 0;

  localparam int BITCLK = 64;

  // {len, pmode, pforce, data, flip, exp_data, exp_stat}
  localparam logic [25:0] VEC [8] = '{
    {2'd3, 2'd0, 1'b0, 8'hA5, 1'b0, 8'hA5, 4'h0},
    {2'd0, 2'd0, 1'b0, 8'hFF, 1'b0, 8'h1F, 4'h0},
    {2'd1, 2'd1, 1'b0, 8'h2A, 1'b0, 8'h2A, 4'h0},
    {2'd2, 2'd2, 1'b0, 8'h55, 1'b1, 8'h55, 4'h1},
    {2'd3, 2'd3, 1'b1, 8'h3C, 1'b1, 8'h3C, 4'h1},
    {2'd3, 2'd1, 1'b0, 8'h00, 1'b0, 8'h00, 4'h0},
    {2'd0, 2'd2, 1'b0, 8'h15, 1'b1, 8'h15, 4'h1},
    {2'd2, 2'd3, 1'b0, 8'h7F, 1'b0, 8'h7F, 4'h0}
  };

  serial_rx_buf u0 (
    .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rx_line(rx_line),
    .len_sel(len_sel), .par_mode(par_mode), .par_force(par_force),
    .flow_en(flow_en), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_stat(out_stat), .buf_full(buf_full),
    .rts_n(rts_n), .brk_start(brk_start), .brk_end(brk_end)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tdiv    <= tdiv + 1'b1;
    rx_tick <= (tdiv == 2'd3);
    if (rst_n && brk_start) n_bs <= n_bs + 1;
    if (rst_n && brk_end)   n_be <= n_be + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rx_line = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send_char(input logic [1:0] l, input logic [1:0] pm, input logic pf,
                           input logic [7:0] d, input logic flip, input logic stop);
    logic [7:0] mask;
    logic p;
    @(negedge clk);
    len_sel = l; par_mode = pm; par_force = pf;
    mask = 8'hFF >> (3 - int'(l));
    p = ^(d & mask);
    if (pm == 2'd2) p = ~p;
    else if (pm == 2'd3) p = pf;
    send_bit(1'b0);
    for (int b = 0; b < 5 + int'(l); b++) send_bit(d[b]);
    if (pm != 2'd0) send_bit(p ^ flip);
    send_bit(stop);
    rx_line = 1'b1;
    repeat (32) @(negedge clk);
  endtask

  task automatic pop_check(input string req, input logic [7:0] ed, input logic [3:0] es);
    @(negedge clk);
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check({req, " data"}, 32'(out_data), 32'(ed));
    check({req, " status"}, 32'(out_stat), 32'(es));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 valid", 32'(out_valid), 32'd0);
    check("R11 full", 32'(buf_full), 32'd0);
    check("R11 rts_n", 32'(rts_n), 32'd0);
    check("R11 brk pulses", 32'({brk_start, brk_end}), 32'd0);

    // R1 R2 R10: format table
    for (int i = 0; i < 8; i++) begin
      logic [25:0] v;
      v = VEC[i];
      send_char(v[25:24], v[23:22], v[21], v[20:13], v[12], 1'b1);
      pop_check($sformatf("R1 R2 R10 vec%0d", i), v[11:4], v[3:0]);
      check($sformatf("R5 empty after vec%0d", i), 32'(out_valid), 32'd0);
    end

    // R4 false start: low for 3 ticks only
    @(negedge clk);
    len_sel = 2'd3; par_mode = 2'd0;
    rx_line = 1'b0;
    repeat (12) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    check("R4 no char from glitch", 32'(out_valid), 32'd0);
    send_char(2'd3, 2'd0, 1'b0, 8'h6B, 1'b0, 1'b1);
    pop_check("R4 clean char after glitch", 8'h6B, 4'h0);

    // R3 R8 framing error; the low stop sample starts an all-mark character
    send_char(2'd3, 2'd0, 1'b0, 8'h81, 1'b0, 1'b0);
    repeat (10 * BITCLK) @(negedge clk);
    pop_check("R3 framing entry", 8'h81, 4'h2);
    pop_check("R8 stop reused as start", 8'hFF, 4'h0);

    // R5 R6 R9 fill, hold and overrun
    @(negedge clk);
    flow_en = 1'b1;
    send_char(2'd3, 2'd0, 1'b0, 8'h11, 1'b0, 1'b1);
    send_char(2'd3, 2'd0, 1'b0, 8'h22, 1'b0, 1'b1);
    send_char(2'd3, 2'd0, 1'b0, 8'h33, 1'b0, 1'b1);
    check("R5 not full at 3", 32'(buf_full), 32'd0);
    check("R9 rts low at 3", 32'(rts_n), 32'd0);
    send_char(2'd3, 2'd0, 1'b0, 8'h44, 1'b0, 1'b1);
    check("R5 full at 4", 32'(buf_full), 32'd1);
    check("R9 rts negated when full", 32'(rts_n), 32'd1);
    flow_en = 1'b0;
    @(negedge clk);
    check("R9 rts with flow off", 32'(rts_n), 32'd0);
    flow_en = 1'b1;
    send_char(2'd3, 2'd0, 1'b0, 8'h55, 1'b0, 1'b1);
    repeat (40) @(negedge clk);
    check("R5 head held without ready", 32'(out_data), 32'h11);
    pop_check("R6 entry0", 8'h11, 4'h0);
    check("R9 rts released after pop", 32'(rts_n), 32'd0);
    pop_check("R6 entry1", 8'h22, 4'h0);
    pop_check("R6 entry2", 8'h33, 4'h0);
    pop_check("R6 newest carries overrun", 8'h44, 4'h8);
    check("R6 dropped char absent", 32'(out_valid), 32'd0);
    flow_en = 1'b0;

    // R7 full break from idle
    @(negedge clk);
    len_sel = 2'd3; par_mode = 2'd0;
    rx_line = 1'b0;
    repeat (14 * BITCLK) @(negedge clk);
    check("R7 brk_start count", 32'(n_bs), 32'd1);
    pop_check("R7 break entry", 8'h00, 4'h6);
    repeat (4 * BITCLK) @(negedge clk);
    check("R7 no entry while held low", 32'(out_valid), 32'd0);
    check("R7 no end while low", 32'(n_be), 32'd0);
    rx_line = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
    check("R7 brk_end count", 32'(n_be), 32'd1);
    check("R7 no entry at mark", 32'(out_valid), 32'd0);

    // R8 break that starts mid-character
    send_bit(1'b0);
    for (int b = 0; b < 4; b++) send_bit(1'b1);
    rx_line = 1'b0;
    repeat (20 * BITCLK) @(negedge clk);
    rx_line = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
    pop_check("R8 partial char", 8'h0F, 4'h2);
    pop_check("R8 break after partial", 8'h00, 4'h6);
    check("R8 brk_start count", 32'(n_bs), 32'd2);
    check("R8 brk_end count", 32'(n_be), 32'd2);
    check("R8 buffer drained", 32'(out_valid), 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule